// File: doc/BRIEF.md
# Six-Channel Packed Audio Serializer

This block turns six two's-complement audio samples per frame (three left channels, three right channels) into one serial data line. It produces a square bit clock, a one-cycle bit tick and a left/right frame clock alongside the data line. Everything runs from a single system clock. One bit period lasts `DIV` system clocks.

Two frame layouts are available. The first is a compact 128-bit frame with 20-bit slots and short 4-bit gaps. The second is a roomy 256-bit frame with 32-bit slots, where each word is delayed by one bit. A word-length selector picks 16, 20 or 24 significant bits.

Sample sets are offered on a parallel bus with a ready/valid handshake. An accepted set is held in a staging register and becomes active only at the next frame boundary, so a frame never mixes two sets. If no new set arrives, the previous set repeats. The layout and word-length selections are sampled at the frame boundary as well.

Top module: `pk6_serializer`

## Requirements
- R1: `bit_tick` is high for exactly one system clock every `DIV` clocks. On the clock edge that ends a tick cycle, `bclk` falls and `sdata` and `lrclk` take their next value. `bclk` rises `DIV/2` clocks after each fall, and `sdata` and `lrclk` change at no other edge.
- R2: With `frame_256`=0 a frame is 128 bits, numbered from 0. L0, L1 and L2 occupy bits 0-19, 20-39 and 40-59, and bits 60-63 are blank. R0, R1 and R2 occupy bits 64-83, 84-103 and 104-123, and bits 124-127 are blank. Each word's MSB is the first bit of its slot.
- R3: With `frame_256`=1 a frame is 256 bits, made of eight 32-bit slots in the order L0, L1, L2, blank, R0, R1, R2, blank. Each word's MSB is sent on bit 1 of its slot, and bit 0 of every slot is 0.
- R4: Words are sent MSB first. `wl_sel` 0 selects 16 bits, 1 selects 20 bits, and 2 or 3 select 24 bits. An n-bit word is bits [23:24-n] of the channel's 24-bit sample. Channel k of `in_samples` sits at bits [24k+23:24k], with k=0..2 for left 0..2 and k=3..5 for right 0..2.
- R5: Every bit after a word's last bit inside its slot is 0, and every bit of a blank slot is 0.
- R6: In the 128-bit layout, a 24-bit selection is reduced to 20 bits, sending sample bits [23:4].
- R7: `lrclk` is high for bits 0-63 and low for bits 64-127 of a 128-bit frame. It is low for bits 0-127 and high for bits 128-255 of a 256-bit frame.
- R8: `in_ready` is high while the staging register is empty. A set is taken on a clock where `in_valid` and `in_ready` are both high, and `in_ready` then stays low until the next frame boundary. At that boundary the staged set becomes the active set for the new frame. A set taken on the boundary clock itself waits for the following frame. With no staged set, the active set repeats.
- R9: `frame_256` and `wl_sel` are sampled only at the frame boundary, on the tick that starts bit 0. A change in the middle of a frame does not alter that frame.
- R10: While `rst` is high, `sdata`=0, `lrclk`=0, `bclk`=1, `bit_tick`=0 and `in_ready`=1, and the active set is all zeros. The first bit tick after reset starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_256 | input | 1 | Layout select: 0 = 128-bit frame, 1 = 256-bit frame |
| wl_sel | input | 2 | Word length: 0 = 16, 1 = 20, 2/3 = 24 bits |
| in_samples | input | 144 | Six 24-bit samples, channel k at [24k+23:24k] |
| in_valid | input | 1 | Sample set offered |
| in_ready | output | 1 | Staging register empty |
| bit_tick | output | 1 | One-clock pulse preceding each bit period |
| bclk | output | 1 | Bit clock; data changes on its falling edge |
| lrclk | output | 1 | Left/right frame clock |
| sdata | output | 1 | Serial data |

## Verification
The embedded assertions check the following on every cycle:
- `bit_tick` is a single-clock pulse, and `bclk` falls right after it.
- `sdata` and `lrclk` hold still between ticks.
- Blank positions and the leading pad bit of 256-bit slots carry 0.
- `in_ready` drops after each accepted set.

The bench's scenarios show everything that needs frame context. This includes the exact slot placement and word truncation under every layout and word-length combination, the polarity of `lrclk` per layout, and the handover of a staged set at the frame boundary. It also covers mode changes issued mid-frame that must wait for the next boundary, and the repeated set when nothing new is loaded.

// File: rtl/pk6_serializer.sv
`timescale 1ns/1ps
module pk6_serializer #(
  parameter int DIV = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frame_256,
  input  logic [1:0]   wl_sel,
  input  logic [143:0] in_samples,
  input  logic         in_valid,
  output logic         in_ready,
  output logic         bit_tick,
  output logic         bclk,
  output logic         lrclk,
  output logic         sdata
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);
  localparam logic [DW-1:0] HALF = DW'(DIV / 2 - 1);

  logic [DW-1:0]  div_cnt;
  logic [7:0]     pos, npos;
  logic           mode_q, nmode;
  logic [4:0]     wl_q, nwl, d;
  logic [2:0]     ch;
  logic [5:0]     lo6;
  logic [143:0]   stage, shadow, nset;
  logic           full, blank, nbit, wrap, accept;
  int             idx;

  assign bit_tick = (div_cnt == LAST);
  assign in_ready = !full;
  assign accept   = in_valid && !full;
  assign wrap     = bit_tick && (pos == (mode_q ? 8'd255 : 8'd127));
  assign npos     = wrap ? 8'd0 : pos + 8'd1;
  assign nmode    = wrap ? frame_256 : mode_q;
  assign nwl      = !wrap ? wl_q : (wl_sel == 2'd0) ? 5'd16 :
                    (wl_sel == 2'd1 || !frame_256) ? 5'd20 : 5'd24;
  assign nset     = (wrap && full) ? stage : shadow;
  assign lo6      = npos[5:0];

  always_comb begin
    blank = 1'b0;
    ch    = 3'd0;
    d     = 5'd0;
    if (nmode) begin
      blank = (npos[6:5] == 2'd3) || (npos[4:0] == 5'd0);
      ch    = {1'b0, npos[6:5]} + (npos[7] ? 3'd3 : 3'd0);
      d     = npos[4:0] - 5'd1;
    end else begin
      blank = (lo6 >= 6'd60);
      if (lo6 < 6'd20) begin
        ch = 3'd0; d = lo6[4:0];
      end else if (lo6 < 6'd40) begin
        ch = 3'd1; d = 5'(lo6 - 6'd20);
      end else begin
        ch = 3'd2; d = 5'(lo6 - 6'd40);
      end
      if (npos[6]) ch = ch + 3'd3;
    end
    idx  = (!blank && d < nwl) ? int'(ch) * 24 + 23 - int'(d) : 0;
    nbit = !blank && (d < nwl) && nset[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      bclk    <= 1'b1;
    end else if (bit_tick) begin
      div_cnt <= '0;
      bclk    <= 1'b0;
    end else begin
      div_cnt <= div_cnt + DW'(1);
      if (div_cnt == HALF) bclk <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos    <= 8'hFF;
      mode_q <= 1'b1;
      wl_q   <= 5'd24;
      sdata  <= 1'b0;
      lrclk  <= 1'b0;
    end else if (bit_tick) begin
      pos    <= npos;
      mode_q <= nmode;
      wl_q   <= nwl;
      sdata  <= nbit;
      lrclk  <= nmode ? npos[7] : ~npos[6];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      stage  <= '0;
      full   <= 1'b0;
    end else begin
      if (accept) stage <= in_samples;
      if (wrap) begin
        if (full) shadow <= stage;
        full <= accept;
      end else if (accept) begin
        full <= 1'b1;
      end
    end
  end

  a_r1_tick_single: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> !bit_tick);
  a_r1_bclk_falls: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> $fell(bclk));
  a_r1_data_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_tick) |-> ($stable(sdata) && $stable(lrclk)));
  a_r5_blank128_zero: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && pos[5:0] >= 6'd60) |-> !sdata);
  a_r3_pad256_zero: assert property (@(posedge clk) disable iff (rst)
    (mode_q && (pos[4:0] == 5'd0 || pos[6:5] == 2'd3)) |-> !sdata);
  a_r8_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
endmodule

// File: tb/pk6_serializer_test.sv
`timescale 1ns/1ps
module pk6_serializer_test;
  localparam int DIV = 4;
  logic clk = 0, rst = 1, frame_256 = 1, in_valid = 0;
  logic [1:0] wl_sel = 2'd2;
  logic [143:0] in_samples = '0;
  logic in_ready, bit_tick, bclk, lrclk, sdata;
  int n_tests = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  pk6_serializer #(.DIV(DIV)) uut (.*);

  always #10 clk = ~clk;

  function automatic logic exp_bit(int p, logic m256, logic [1:0] w, logic [143:0] s);
    int n, ch, d, sl, q;
    n = (w == 0) ? 16 : (w == 1) ? 20 : 24;
    if (!m256 && n > 20) n = 20;
    if (m256) begin
      sl = p / 32;
      if (sl == 3 || sl == 7 || p % 32 == 0) return 1'b0;
      ch = (sl < 3) ? sl : sl - 1;
      d  = p % 32 - 1;
    end else begin
      q = p % 64;
      if (q >= 60) return 1'b0;
      ch = q / 20 + ((p >= 64) ? 3 : 0);
      d  = q % 20;
    end
    if (d >= n) return 1'b0;
    return s[ch*24 + 23 - d];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // bench model state
  int m_pos = 255, gap = 0;
  logic m_mode = 1, m_full = 0, chk_next = 0, seen_tick = 0;
  logic [1:0] m_wl = 2'd2;
  logic [143:0] m_act = '0, m_pend = '0;

  always @(negedge clk) begin
    cycles++;
    if (!rst && !done) begin
      gap++;
      if (chk_next) begin
        check(bclk == 0, "R1 bclk fall", bclk, 0);
        check(sdata == exp_bit(m_pos, m_mode, m_wl, m_act),
              m_mode ? "R3/R4/R5 sdata 256" : "R2/R4/R5/R6 sdata 128",
              sdata, exp_bit(m_pos, m_mode, m_wl, m_act));
        check(lrclk == (m_mode ? (m_pos >= 128) : (m_pos < 64)), "R7 lrclk",
              lrclk, m_mode ? (m_pos >= 128) : (m_pos < 64));
        chk_next = 0;
      end
      check(in_ready == !m_full, "R8 in_ready", in_ready, !m_full);
      if (bit_tick) begin
        if (seen_tick) check(gap == DIV, "R1 tick period", gap, DIV);
        seen_tick = 1;
        gap = 0;
        if (m_pos == (m_mode ? 255 : 127)) begin
          m_pos = 0;
          m_mode = frame_256;  // R9 sampled at boundary only
          m_wl = wl_sel;
          if (m_full) begin m_act = m_pend; m_full = 0; end
        end else m_pos++;
        chk_next = 1;
      end
      if (in_valid && in_ready) begin m_pend = in_samples; m_full = 1; end
    end
  end

  task automatic load(logic [143:0] s);
    logic r;
    @(posedge clk); #1;
    in_valid = 1; in_samples = s;
    forever begin
      @(negedge clk); r = in_ready;
      @(posedge clk);
      if (r) break;
    end
    #1 in_valid = 0; in_samples = {$urandom, $urandom, $urandom, $urandom, 16'(0)};
  endtask

  task automatic set_mode(logic m, logic [1:0] w);
    @(posedge clk); #1; frame_256 = m; wl_sel = w;
  endtask

  function automatic logic [143:0] rnd_set();
    logic [143:0] s;
    for (int k = 0; k < 6; k++) s[k*24 +: 24] = 24'($urandom);
    return s;
  endfunction

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check(sdata == 0, "R10 sdata", sdata, 0);
    check(lrclk == 0, "R10 lrclk", lrclk, 0);
    check(bclk == 1, "R10 bclk", bclk, 1);
    check(bit_tick == 0, "R10 bit_tick", bit_tick, 0);
    check(in_ready == 1, "R10 in_ready", in_ready, 1);
    @(posedge clk); #1 rst = 0;
    // first frame carries the all-zero active set (R10)
    repeat (DIV * 300) @(posedge clk);
    // directed: R6 truncation, extremes
    set_mode(0, 2'd2);
    load({24'h800000, 24'h7FFFFF, 24'hFFFFFF, 24'h000001, 24'hA5A5A5, 24'h123456});
    load({24'h7FFFFF, 24'h800000, 24'h00000F, 24'hF0000F, 24'h5A5A5A, 24'hFEDCBA});
    set_mode(0, 2'd0);
    load(rnd_set());
    set_mode(1, 2'd0);
    load(rnd_set());
    set_mode(1, 2'd1);
    load(rnd_set());
    set_mode(1, 2'd3);
    load(rnd_set());
    set_mode(0, 2'd1);
    load(rnd_set());
    // R9: mid-frame changes must wait for boundary; R8 repeat without load
    for (int i = 0; i < 20; i++) begin
      repeat ($urandom_range(0, DIV * 200)) @(posedge clk);
      set_mode(1'($urandom), 2'($urandom));
      if ($urandom_range(0, 3) != 0) load(rnd_set());
    end
    repeat (DIV * 600) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000 && !done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule